// File: doc/BRIEF.md
# Serial Configuration Load Port

This block receives a short configuration word over a three-wire serial link and holds it as the settings of a converter-style device. While the active-low select line is low, each active serial clock edge takes one data bit, most significant first. A frame has nine bits. It opens with a leading marker bit that must be 1, followed by eight payload bits. The payload is written into the held register only on the ninth edge. Until that edge, the previous settings stay in force. Four payload positions are reserved, and a frame never changes them.

The serial clock, data and select are brought into the system clock domain through two-flop synchronizers, and edges are found in that domain. For this reason the system clock must run at least four times faster than the serial clock. A polarity input picks which serial clock edge is active. A mode input picks where the outputs come from. In software mode they come from the held register. In hardware mode they follow four dedicated pins, and serial frames are dropped. The outputs are the polarity, span, power-down and coding flags, and a two-bit code that names the analog input range.

Top module: `cfg_serial_port`

## Requirements
- R1: Serial clock edges that arrive while `cs_n` is high shift nothing and commit nothing.
- R2: The active serial edge is rising when `sclk_inv` is 0 and falling when `sclk_inv` is 1. Edges of the other polarity are ignored.
- R3: The first active edge after `cs_n` falls carries the marker bit. If that bit is 0, every further edge is ignored until `cs_n` goes high.
- R4: The payload is committed on the ninth active edge. Outputs keep their old values until then. They take the new value three system clock cycles after the serial edge at the pin (two synchronizer stages and one register). Edges after the ninth are ignored until `cs_n` goes high.
- R5: Payload bit 7 (the second bit sent) sets `bipolar`. Bit 6 sets `wide_span`. Bit 5 sets `power_down`. Bit 2 sets `straight_bin`, where 1 selects straight binary and 0 selects two's complement coding.
- R6: Payload bits 4, 3, 1 and 0 are reserved. A commit leaves them unchanged, so they read back as 0 on `cfg_word`.
- R7: Reset clears the whole register to 0. This gives the 0–5 V range, normal operation and two's complement coding.
- R8: `range_code` is {bipolar, wide_span}. 00 means 0–5 V, 01 means 0–10 V, 10 means ±5 V and 11 means ±10 V.
- R9: Frames are still accepted while `power_down` is 1. A later frame with bit 5 at 0 clears it.
- R10: When `sw_mode` is 0, the flag outputs follow `pin_bipolar`, `pin_wide`, `pin_pwrdn` and `pin_straight`, and serial frames do not change the register.
- R11: If `cs_n` rises before the ninth edge, the partial frame is discarded with no commit. The next selection starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_mode | input | 1 | 1: outputs from serial register; 0: outputs from pins |
| cs_n | input | 1 | Active-low serial select |
| sclk | input | 1 | Serial clock |
| sdata | input | 1 | Serial data, MSB first |
| sclk_inv | input | 1 | 0: rising active edge; 1: falling active edge |
| pin_bipolar | input | 1 | Hardware-mode polarity flag |
| pin_wide | input | 1 | Hardware-mode span flag |
| pin_pwrdn | input | 1 | Hardware-mode power-down flag |
| pin_straight | input | 1 | Hardware-mode coding flag |
| range_code | output | 2 | Input range code |
| bipolar | output | 1 | Active polarity flag |
| wide_span | output | 1 | Active span flag |
| power_down | output | 1 | Active power-down flag |
| straight_bin | output | 1 | Active coding flag |
| cfg_word | output | 8 | Held serial register payload |

## Verification
The bench goes after the framing edge cases. One is a frame whose marker bit is 0 followed by a well-formed word under the same select. A design that re-armed after the bad marker would commit that later word. Another is a select released after five bits and then a fresh frame. A counter that was not cleared would commit at the wrong edge with shifted data. The bench also checks edges past the ninth and edges sent while deselected, both of which would corrupt the register if honoured. It uses both clock polarities, and data changes on the inactive edge, so sampling on the wrong edge produces a skewed word. The reference model is checked on every cycle. A wrong commit edge, a write into reserved bits, or a stale output after a hardware-to-software mode switch shows up in the exact cycle where it occurs.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  localparam int FRAME_BITS = 9;
  localparam int PAY_W      = FRAME_BITS - 1;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  localparam int POS_BIPOLAR  = 7;
  localparam int POS_WIDE     = 6;
  localparam int POS_PWRDN    = 5;
  localparam int POS_STRAIGHT = 2;

  // positions a frame may not touch
  localparam logic [PAY_W-1:0] RSV_MASK = 8'b0001_1011;

  typedef enum logic [1:0] {
    FR_IDLE   = 2'd0,
    FR_SHIFT  = 2'd1,
    FR_REJECT = 2'd2,
    FR_DONE   = 2'd3
  } frame_st_e;

  typedef enum logic [1:0] {
    RNG_UNI_5  = 2'b00,
    RNG_UNI_10 = 2'b01,
    RNG_BI_5   = 2'b10,
    RNG_BI_10  = 2'b11
  } range_e;

  function automatic range_e range_of(input logic bip, input logic wide);
    range_e r;
    unique case ({bip, wide})
      2'b00:   r = RNG_UNI_5;
      2'b01:   r = RNG_UNI_10;
      2'b10:   r = RNG_BI_5;
      default: r = RNG_BI_10;
    endcase
    return r;
  endfunction

  function automatic logic [PAY_W-1:0] cfg_merge(input logic [PAY_W-1:0] old_v,
                                                 input logic [PAY_W-1:0] new_v);
    return (old_v & RSV_MASK) | (new_v & ~RSV_MASK);
  endfunction

endpackage

// File: rtl/cfg_sync_bit.sv
module cfg_sync_bit #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sdata_i,
  input  logic cs_n_i,
  input  logic inv_i,
  output logic sdata_s_o,
  output logic cs_n_s_o,
  output logic act_edge_o
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] RST_VALS = 3'b100; // cs_n idles high

  logic [NSIG-1:0] raw_in;
  logic [NSIG-1:0] synced;
  logic            sclk_s, sclk_prev_q;
  logic            rise_w, fall_w;

  assign raw_in = {cs_n_i, sdata_i, sclk_i};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    cfg_sync_bit #(.STAGES(STAGES), .RST_VAL(RST_VALS[g])) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (raw_in[g]),
      .q_o  (synced[g])
    );
  end

  assign sclk_s    = synced[0];
  assign sdata_s_o = synced[1];
  assign cs_n_s_o  = synced[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= sclk_s;
  end

  assign rise_w     = sclk_s & ~sclk_prev_q;
  assign fall_w     = ~sclk_s & sclk_prev_q;
  assign act_edge_o = inv_i ? fall_w : rise_w;

  AST_EDGE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (act_edge_o && !inv_i) |-> sclk_s); // R2
  AST_EDGE_FALLING: assert property (@(posedge clk) disable iff (!rst_n)
    (act_edge_o && inv_i) |-> !sclk_s); // R2
endmodule

// File: rtl/cfg_frame_shifter.sv
module cfg_frame_shifter
  import cfg_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             cs_n_s_i,
  input  logic             sdata_s_i,
  input  logic             act_edge_i,
  output logic             commit_o,
  output logic [PAY_W-1:0] word_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS - 1);

  frame_st_e        state_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic [PAY_W-1:0] shreg_q;
  logic             live_edge;

  assign live_edge = act_edge_i && !cs_n_s_i && enable_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= FR_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
    end else if (cs_n_s_i || !enable_i) begin
      state_q   <= FR_IDLE;
      bit_cnt_q <= '0;
    end else if (act_edge_i) begin
      unique case (state_q)
        FR_IDLE: begin
          if (sdata_s_i) begin
            state_q   <= FR_SHIFT;
            bit_cnt_q <= CNT_W'(1);
          end else begin
            state_q   <= FR_REJECT;
          end
        end
        FR_SHIFT: begin
          shreg_q   <= {shreg_q[PAY_W-2:0], sdata_s_i};
          bit_cnt_q <= bit_cnt_q + CNT_W'(1);
          if (bit_cnt_q == LAST_CNT) state_q <= FR_DONE;
        end
        default: state_q <= state_q;
      endcase
    end
  end

  assign commit_o = live_edge && (state_q == FR_SHIFT) && (bit_cnt_q == LAST_CNT);
  assign word_o   = {shreg_q[PAY_W-2:0], sdata_s_i};

  AST_CS_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s_i |=> (bit_cnt_q == '0)); // R11
  AST_COMMIT_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> (state_q == FR_DONE)); // R4
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt_q <= CNT_W'(FRAME_BITS)); // R3
  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FR_REJECT && !cs_n_s_i && enable_i) |=> (state_q == FR_REJECT)); // R3
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  logic [PAY_W-1:0] word_i,
  output logic [PAY_W-1:0] cfg_q_o
);
  logic [PAY_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= '0;
    else if (commit_i) cfg_q <= cfg_merge(cfg_q, word_i);
  end

  assign cfg_q_o = cfg_q;

  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(cfg_q)); // R4
  AST_RSV_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> ((cfg_q & RSV_MASK) == ($past(cfg_q) & RSV_MASK))); // R6
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_mode,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdata,
  input  logic       sclk_inv,
  input  logic       pin_bipolar,
  input  logic       pin_wide,
  input  logic       pin_pwrdn,
  input  logic       pin_straight,
  output logic [1:0] range_code,
  output logic       bipolar,
  output logic       wide_span,
  output logic       power_down,
  output logic       straight_bin,
  output logic [7:0] cfg_word
);
  logic             sdata_s, cs_n_s, act_edge;
  logic             commit;
  logic [PAY_W-1:0] frame_word;
  logic [PAY_W-1:0] cfg_q;

  cfg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_i    (sclk),
    .sdata_i   (sdata),
    .cs_n_i    (cs_n),
    .inv_i     (sclk_inv),
    .sdata_s_o (sdata_s),
    .cs_n_s_o  (cs_n_s),
    .act_edge_o(act_edge)
  );

  cfg_frame_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable_i  (sw_mode),
    .cs_n_s_i  (cs_n_s),
    .sdata_s_i (sdata_s),
    .act_edge_i(act_edge),
    .commit_o  (commit),
    .word_o    (frame_word)
  );

  cfg_reg_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit_i(commit),
    .word_i  (frame_word),
    .cfg_q_o (cfg_q)
  );

  always_comb begin
    if (sw_mode) begin
      bipolar      = cfg_q[POS_BIPOLAR];
      wide_span    = cfg_q[POS_WIDE];
      power_down   = cfg_q[POS_PWRDN];
      straight_bin = cfg_q[POS_STRAIGHT];
    end else begin
      bipolar      = pin_bipolar;
      wide_span    = pin_wide;
      power_down   = pin_pwrdn;
      straight_bin = pin_straight;
    end
    range_code = range_of(bipolar, wide_span);
  end

  assign cfg_word = cfg_q;

  AST_HW_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_mode |=> $stable(cfg_word)); // R10
  AST_DESELECT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |-> !commit); // R1
endmodule

// File: tb/cfg_serial_port_tb.sv
module cfg_serial_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_mode = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdata = 1'b0, sclk_inv = 1'b0;
  logic pin_bipolar = 1'b0, pin_wide = 1'b0, pin_pwrdn = 1'b0, pin_straight = 1'b0;
  logic [1:0] range_code;
  logic bipolar, wide_span, power_down, straight_bin;
  logic [7:0] cfg_word;

  int tests = 0, fails = 0;
  bit run_cmp = 0, done = 0;

  // reference model state
  logic [7:0] m_reg = '0, m_pval = '0, m_word = '0;
  int m_pend = 0, m_cnt = 0;
  bit m_ok = 0;

  always #4 clk = ~clk;

  cfg_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .sw_mode(sw_mode), .cs_n(cs_n), .sclk(sclk),
    .sdata(sdata), .sclk_inv(sclk_inv), .pin_bipolar(pin_bipolar),
    .pin_wide(pin_wide), .pin_pwrdn(pin_pwrdn), .pin_straight(pin_straight),
    .range_code(range_code), .bipolar(bipolar), .wide_span(wide_span),
    .power_down(power_down), .straight_bin(straight_bin), .cfg_word(cfg_word)
  );

  function automatic logic e_bip();  return sw_mode ? m_reg[7] : pin_bipolar;  endfunction
  function automatic logic e_wide(); return sw_mode ? m_reg[6] : pin_wide;     endfunction
  function automatic logic e_pd();   return sw_mode ? m_reg[5] : pin_pwrdn;    endfunction
  function automatic logic e_sb();   return sw_mode ? m_reg[2] : pin_straight; endfunction
  function automatic logic [1:0] e_rng();
    // R8: 0-5V=00, 0-10V=01, +-5V=10, +-10V=11
    if (e_bip()) return e_wide() ? 2'd3 : 2'd2;
    else         return e_wide() ? 2'd1 : 2'd0;
  endfunction

  // cycle-by-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (m_pend > 0) begin
      m_pend--;
      if (m_pend == 0) m_reg = m_pval;
    end
    if (run_cmp && !done) begin
      tests++;
      if (cfg_word !== m_reg) begin
        fails++; $display("FAIL R6/R4 cycle cfg_word act=%h exp=%h @%0t", cfg_word, m_reg, $time);
      end
      if (bipolar !== e_bip() || wide_span !== e_wide()) begin
        fails++; $display("FAIL R5 cycle bip/wide act=%b%b exp=%b%b @%0t", bipolar, wide_span, e_bip(), e_wide(), $time);
      end
      if (power_down !== e_pd()) begin
        fails++; $display("FAIL R9 cycle power_down act=%b exp=%b @%0t", power_down, e_pd(), $time);
      end
      if (straight_bin !== e_sb()) begin
        fails++; $display("FAIL R5 cycle straight_bin act=%b exp=%b @%0t", straight_bin, e_sb(), $time);
      end
      if (range_code !== e_rng()) begin
        fails++; $display("FAIL R8 cycle range_code act=%b exp=%b @%0t", range_code, e_rng(), $time);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge(input logic b);
    if (!cs_n && sw_mode) begin
      m_cnt++;
      if (m_cnt == 1) m_ok = b;
      else if (m_cnt <= 9) m_word = {m_word[6:0], b};
      if (m_cnt == 9 && m_ok) begin
        m_pval = m_reg;
        m_pval[7] = m_word[7];
        m_pval[6] = m_word[6];
        m_pval[5] = m_word[5];
        m_pval[2] = m_word[2];
        m_pend = 3;
      end
    end
  endtask

  task automatic send_bits(input logic [15:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      sdata = bits[n-1-i];
      tick(4);
      sclk = ~sclk_inv;
      model_edge(bits[n-1-i]);
      tick(4);
      sclk = sclk_inv;
    end
    tick(2);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0; tick(4);
  endtask

  task automatic cs_hi();
    cs_n = 1'b1; m_cnt = 0; m_ok = 0; tick(6);
  endtask

  task automatic frame(input logic [8:0] f);
    cs_lo(); send_bits({7'd0, f}, 9); tick(2); cs_hi();
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    run_cmp = 1;
    tick(2);
    // R7 reset state
    check("R7 reset cfg_word", cfg_word, 8'h00);
    check("R7 reset flags", {4'd0, range_code, power_down, straight_bin}, 8'h00);

    // R5 R6 R8: rising edge frame, reserved ones in frame
    frame(9'b1_1_0_1_11_1_11);
    check("R6 reserved kept, R5 fields", cfg_word, 8'hA4);
    check("R8 range bipolar 5V", {6'd0, range_code}, 8'h02);
    check("R5 straight binary", {7'd0, straight_bin}, 8'h01);

    // R4: eight bits then hold; no change before ninth edge
    cs_lo();
    send_bits({7'd0, 9'b1_0_1_0_00_0_00} >> 1, 8);
    tick(6);
    check("R4 no commit before ninth edge", cfg_word, 8'hA4);
    send_bits(16'd0, 1);
    check("R4 commit on ninth edge", cfg_word, 8'h40);
    // R4 extra edges after ninth ignored
    send_bits(16'hFFFF, 3);
    check("R4 extra edges ignored", cfg_word, 8'h40);
    tick(2); cs_hi();

    // R2: falling-edge polarity
    sclk_inv = 1'b1; tick(2); sclk = 1'b1; tick(6);
    frame(9'b1_0_1_0_00_1_00);
    check("R2 falling edge frame", cfg_word, 8'h44);
    check("R8 range unipolar 10V", {6'd0, range_code}, 8'h01);
    sclk_inv = 1'b0; tick(2); sclk = 1'b0; tick(6);

    // R3: zero marker, then a valid-looking word in the same select
    cs_lo();
    send_bits({6'd0, 10'b0_1_1_1_00_1_00_0}, 10);
    tick(2); cs_hi();
    check("R3 zero marker ignored", cfg_word, 8'h44);

    // R11: partial frame discarded, then a fresh one lands cleanly
    cs_lo(); send_bits({11'd0, 5'b1_1_1_1_1}, 5); tick(2); cs_hi();
    check("R11 partial frame dropped", cfg_word, 8'h44);
    frame(9'b1_1_1_0_00_0_00);
    check("R11 next frame after abort", cfg_word, 8'hC0);

    // R1: edges while deselected
    for (int i = 0; i < 12; i++) begin
      sdata = i[0]; tick(4); sclk = 1'b1; tick(4); sclk = 1'b0;
    end
    tick(6);
    check("R1 deselected edges ignored", cfg_word, 8'hC0);
    frame(9'b1_0_0_0_00_0_00);
    check("R1 frame after deselected edges", cfg_word, 8'h00);

    // R9: power-down set, then cleared by later frame
    frame(9'b1_0_0_1_00_0_00);
    check("R9 power-down set", {7'd0, power_down}, 8'h01);
    frame(9'b1_0_1_0_00_1_00);
    check("R9 power-down cleared", {7'd0, power_down}, 8'h00);

    // R8 all four range codes
    for (int k = 0; k < 4; k++) begin
      logic [1:0] kk;
      kk = 2'(k);
      frame({1'b1, kk, 6'b0});
      check("R8 range sweep", {6'd0, range_code}, {6'd0, kk});
    end

    // R10: hardware mode
    sw_mode = 1'b0;
    pin_bipolar = 1'b1; pin_wide = 1'b0; pin_pwrdn = 1'b1; pin_straight = 1'b1;
    tick(2);
    check("R10 pins drive flags", {4'd0, bipolar, wide_span, power_down, straight_bin}, 8'h0B);
    check("R10 range from pins", {6'd0, range_code}, 8'h02);
    frame(9'b1_0_0_0_00_1_00);
    check("R10 frame ignored in hw mode", cfg_word, 8'hC0);
    sw_mode = 1'b1; tick(2);
    check("R10 register restored on sw mode", {4'd0, bipolar, wide_span, power_down, straight_bin}, 8'h0C);

    // R7 mid-run reset
    rst_n = 1'b0; m_reg = '0; m_pend = 0; tick(2);
    rst_n = 1'b1; tick(2);
    check("R7 reset clears register", cfg_word, 8'h00);
    check("R7 reset range", {6'd0, range_code}, 8'h00);

    tick(4);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule